// File: doc/BRIEF.md
# Four-Error ECC Code Packer and Sector Corrector

This block sits between a four-error BCH-style check engine and a 512-byte sector buffer. On the write path it takes the engine's eight 10-bit check values and produces the 10-byte code that is stored in the spare area. The engine delivers these values as two halves of each of four 32-bit words. On the read path it takes a stored 10-byte code and feeds its eight 10-bit values back to the engine's load port, one per cycle.

After a read, the block is given the engine's syndrome words. When the syndrome is non-zero, the block follows the engine's state field until the error locations are ready. It then walks the reported address/value pairs and turns each address into a byte offset inside the sector. For every offset that lands in the data area, it issues one XOR write to the sector buffer. It ends with a completion pulse that carries either the number of corrections applied or an uncorrectable flag.

Top module: `ecc4_codec`

## Requirements
- R1: One cycle after `pack_valid`, `pack_done` pulses and `pack_code` holds value i in bits [10i+9:10i], so byte b of the code is bits [8b+7:8b]. Value 2k is `chk_words` word k bits 9:0 and value 2k+1 is word k bits 25:16. All other word bits are ignored.
- R2: An accepted `unpack_valid` starts a stream on the load port in the next cycle. The stream is eight consecutive cycles of `load_valid`, carrying code bits [79:70] first and bits [9:0] last. An `unpack_valid` that arrives while a stream is running is ignored.
- R3: If the syndrome is zero after each word is masked to bits 9:0 and 25:16, `corr_done` pulses one cycle after `corr_start` with count 0, no fail flag and no sector write.
- R4: With a non-zero syndrome, the block first waits until `eng_state` is 4 or more, or until `TMO` cycles have passed. Any done value that appears during this wait is ignored.
- R5: While polling, state 0 ends the run with count 0, no fail flag and no write.
- R6: While polling, state 1 ends the run with `corr_fail` set, count 0 and no write.
- R7: While polling, state 2 or 3 gives an error count of 1 plus `eng_errs`. Errors 1 and 2 come from address/value word 0 and errors 3 and 4 from word 1. Odd-numbered errors use bits 15:0 of the word and even-numbered errors use bits 31:16.
- R8: For each error, the offset is 519 minus address bits 9:0. A write happens only when that address lies in 8..519, and the XOR byte is bits 7:0 of the value half.
- R9: Writes come out one per cycle in error order, starting the cycle after the poll that accepts the state. `corr_done` is raised in the cycle of the last error, with `corr_count` equal to the number of writes issued.
- R10: While polling, states 4 to 15 keep the block polling, with no write and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pack_valid | input | 1 | Pack request |
| chk_words | input | 128 | Four engine check words, word k at [32k+31:32k] |
| pack_done | output | 1 | Packed code valid pulse |
| pack_code | output | 80 | Packed 10-byte code, byte 0 in bits 7:0 |
| unpack_valid | input | 1 | Unpack request |
| unpack_code | input | 80 | Stored 10-byte code |
| load_valid | output | 1 | Load port strobe |
| load_value | output | 10 | Value for the engine load port |
| corr_start | input | 1 | Start correction |
| syndrome | input | 128 | Four syndrome words |
| eng_state | input | 4 | Engine state field |
| eng_errs | input | 2 | Engine error count field (count minus one) |
| err_addr | input | 64 | Two address words, error pair per word |
| err_val | input | 64 | Two value words, error pair per word |
| fix_we | output | 1 | Sector XOR write strobe |
| fix_addr | output | 9 | Sector byte offset |
| fix_xor | output | 8 | Byte to XOR into the sector |
| corr_done | output | 1 | Correction run complete pulse |
| corr_fail | output | 1 | Uncorrectable, valid with `corr_done` |
| corr_count | output | 3 | Corrections applied, valid with `corr_done` |

## Verification
The packed code is due one cycle after its request. Load values are due in the eight cycles that follow an accepted unpack. A zero-syndrome completion arrives one cycle after start. In the other runs, the first poll lands one cycle after the wait ends, which is two cycles after start when the engine reports busy at once and TMO+1 cycles after start when it never does. The driver works out each of these due cycles from the stimulus and stores it with every expected item. The monitor rejects any item that appears in another cycle, or that was not expected at all.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;
    localparam int VAL_W   = 10;
    localparam int N_VAL   = 8;
    localparam int N_WORD  = 4;
    localparam int CODE_W  = VAL_W * N_VAL;
    localparam int SECT_B  = 512;
    localparam int OFF_TOP = 519;
    localparam int OFF_W   = $clog2(SECT_B);

    typedef enum logic [1:0] {C_IDLE, C_WAIT, C_POLL, C_FIX} cst_t;

    typedef struct packed {
        logic             we;
        logic [OFF_W-1:0] off;
        logic [7:0]       xv;
    } fix_t;

    function automatic logic [CODE_W-1:0] pack_words(input logic [32*N_WORD-1:0] w);
        logic [CODE_W-1:0] r;
        for (int k = 0; k < N_WORD; k++) begin
            r[2*VAL_W*k +: VAL_W]         = w[32*k +: VAL_W];
            r[2*VAL_W*k + VAL_W +: VAL_W] = w[32*k + 16 +: VAL_W];
        end
        return r;
    endfunction

    function automatic fix_t map_err(input logic [VAL_W-1:0] a, input logic [7:0] v);
        fix_t f;
        logic [VAL_W-1:0] d;
        d    = VAL_W'(OFF_TOP) - a;
        f.we = (a >= VAL_W'(OFF_TOP - SECT_B + 1)) && (a <= VAL_W'(OFF_TOP));
        f.off = d[OFF_W-1:0];
        f.xv = v;
        return f;
    endfunction
endpackage

// File: rtl/ecc4_packer.sv
module ecc4_packer
    import ecc4_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pack_valid,
    input  logic [32*N_WORD-1:0]    chk_words,
    output logic                    pack_done,
    output logic [CODE_W-1:0]       pack_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pack_done <= 1'b0;
            pack_code <= '0;
        end else begin
            pack_done <= pack_valid;
            if (pack_valid) pack_code <= pack_words(chk_words);
        end
    end

    p_pack_latency_r1: assert property (@(posedge clk) disable iff (rst)
        pack_valid |=> pack_done);
    p_pack_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !pack_valid |=> !pack_done);
endmodule

// File: rtl/ecc4_unpacker.sv
module ecc4_unpacker
    import ecc4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              unpack_valid,
    input  logic [CODE_W-1:0] unpack_code,
    output logic              load_valid,
    output logic [VAL_W-1:0]  load_value
);
    localparam int PW = $clog2(N_VAL);

    logic              busy;
    logic [PW-1:0]     ptr;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            ptr        <= '0;
            code_q     <= '0;
            load_valid <= 1'b0;
            load_value <= '0;
        end else begin
            load_valid <= 1'b0;
            if (busy) begin
                load_valid <= 1'b1;
                load_value <= code_q[ptr*VAL_W +: VAL_W];
                if (ptr == '0) busy <= 1'b0;
                else           ptr  <= ptr - 1'b1;
            end else if (unpack_valid) begin
                code_q     <= unpack_code;
                load_valid <= 1'b1;
                load_value <= unpack_code[CODE_W-1 -: VAL_W];
                ptr        <= PW'(N_VAL - 2);
                busy       <= 1'b1;
            end
        end
    end

    p_load_first_r2: assert property (@(posedge clk) disable iff (rst)
        (unpack_valid && !busy) |=> (load_valid && load_value == $past(unpack_code[CODE_W-1 -: VAL_W])));
    p_busy_streams_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> load_valid);
endmodule

// File: rtl/ecc4_corrector.sv
module ecc4_corrector
    import ecc4_pkg::*;
#(
    parameter int TMO = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 corr_start,
    input  logic [32*N_WORD-1:0] syndrome,
    input  logic [3:0]           eng_state,
    input  logic [1:0]           eng_errs,
    input  logic [63:0]          err_addr,
    input  logic [63:0]          err_val,
    output fix_t                 fix,
    output logic                 done,
    output logic                 fail,
    output logic [2:0]           count
);
    localparam int TW = $clog2(TMO + 1);
    localparam logic [31:0] SYN_MASK = 32'h03FF_03FF;

    cst_t          st;
    logic [TW-1:0] tcnt;
    logic [2:0]    num, acc, acc_n;
    logic [1:0]    idx;
    logic [31:0]   aw, vw;
    logic [15:0]   ah, vh;
    logic          syn_nz;
    fix_t          m;
    logic          unused_bits;

    always_comb begin
        syn_nz = 1'b0;
        for (int k = 0; k < N_WORD; k++) syn_nz |= |(syndrome[32*k +: 32] & SYN_MASK);
        aw    = idx[1] ? err_addr[63:32] : err_addr[31:0];
        vw    = idx[1] ? err_val[63:32]  : err_val[31:0];
        ah    = idx[0] ? aw[31:16] : aw[15:0];
        vh    = idx[0] ? vw[31:16] : vw[15:0];
        m     = map_err(ah[VAL_W-1:0], vh[7:0]);
        acc_n = acc + {2'b0, m.we};
    end

    assign unused_bits = ^{ah[15:VAL_W], vh[15:8]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= C_IDLE;
            tcnt  <= '0;
            num   <= '0;
            acc   <= '0;
            idx   <= '0;
            fix   <= '0;
            done  <= 1'b0;
            fail  <= 1'b0;
            count <= '0;
        end else begin
            fix.we <= 1'b0;
            done   <= 1'b0;
            case (st)
                C_IDLE: if (corr_start) begin
                    if (!syn_nz) begin
                        done  <= 1'b1;
                        fail  <= 1'b0;
                        count <= '0;
                    end else begin
                        st   <= C_WAIT;
                        tcnt <= '0;
                    end
                end
                C_WAIT: begin
                    if (eng_state >= 4'd4 || tcnt == TW'(TMO - 1)) st <= C_POLL;
                    else tcnt <= tcnt + 1'b1;
                end
                C_POLL: begin
                    case (eng_state)
                        4'd0, 4'd1: begin
                            done  <= 1'b1;
                            fail  <= eng_state[0];
                            count <= '0;
                            st    <= C_IDLE;
                        end
                        4'd2, 4'd3: begin
                            num <= {1'b0, eng_errs} + 3'd1;
                            idx <= '0;
                            acc <= '0;
                            st  <= C_FIX;
                        end
                        default: st <= C_POLL;
                    endcase
                end
                C_FIX: begin
                    fix <= m;
                    if ({1'b0, idx} == num - 3'd1) begin
                        done  <= 1'b1;
                        fail  <= 1'b0;
                        count <= acc_n;
                        st    <= C_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        acc <= acc_n;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    p_zero_syn_r3: assert property (@(posedge clk) disable iff (rst)
        (st == C_IDLE && corr_start && !syn_nz) |=> (done && count == 3'd0 && !fix.we));
    p_uncorr_r6: assert property (@(posedge clk) disable iff (rst)
        (st == C_POLL && eng_state == 4'd1) |=> (done && fail && !fix.we));
    p_fail_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> count == 3'd0);
    p_count_max_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> count <= 3'd4);
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st == C_POLL && eng_state >= 4'd4) |=> (!done && !fix.we));
    p_wait_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (st == C_WAIT) |-> tcnt < TW'(TMO));
endmodule

// File: rtl/ecc4_codec.sv
module ecc4_codec
    import ecc4_pkg::*;
#(
    parameter int TMO = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pack_valid,
    input  logic [127:0] chk_words,
    output logic         pack_done,
    output logic [79:0]  pack_code,
    input  logic         unpack_valid,
    input  logic [79:0]  unpack_code,
    output logic         load_valid,
    output logic [9:0]   load_value,
    input  logic         corr_start,
    input  logic [127:0] syndrome,
    input  logic [3:0]   eng_state,
    input  logic [1:0]   eng_errs,
    input  logic [63:0]  err_addr,
    input  logic [63:0]  err_val,
    output logic         fix_we,
    output logic [8:0]   fix_addr,
    output logic [7:0]   fix_xor,
    output logic         corr_done,
    output logic         corr_fail,
    output logic [2:0]   corr_count
);
    fix_t fx;

    ecc4_packer u_pack (
        .clk(clk), .rst(rst), .pack_valid(pack_valid), .chk_words(chk_words),
        .pack_done(pack_done), .pack_code(pack_code)
    );

    ecc4_unpacker u_unpack (
        .clk(clk), .rst(rst), .unpack_valid(unpack_valid), .unpack_code(unpack_code),
        .load_valid(load_valid), .load_value(load_value)
    );

    ecc4_corrector #(.TMO(TMO)) u_corr (
        .clk(clk), .rst(rst), .corr_start(corr_start), .syndrome(syndrome),
        .eng_state(eng_state), .eng_errs(eng_errs), .err_addr(err_addr), .err_val(err_val),
        .fix(fx), .done(corr_done), .fail(corr_fail), .count(corr_count)
    );

    assign fix_we   = fx.we;
    assign fix_addr = fx.off;
    assign fix_xor  = fx.xv;
endmodule

// File: tb/tb_ecc4_codec.sv
module tb_ecc4_codec;
    localparam int CLK_P = 10;
    localparam int TMO   = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic pack_valid = 0, unpack_valid = 0, corr_start = 0;
    logic [127:0] chk_words = '0, syndrome = '0;
    logic [79:0]  unpack_code = '0, pack_code;
    logic [3:0]   eng_state = '0;
    logic [1:0]   eng_errs = '0;
    logic [63:0]  err_addr = '0, err_val = '0;
    logic pack_done, load_valid, fix_we, corr_done, corr_fail;
    logic [9:0] load_value;
    logic [8:0] fix_addr;
    logic [7:0] fix_xor;
    logic [2:0] corr_count;

    ecc4_codec #(.TMO(TMO)) dut (.*);

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0, nchk = 0, nfail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int cyc; logic [79:0] d; string req; } item_t;
    item_t q_pack[$], q_load[$], q_fix[$], q_done[$];

    function automatic void check(bit ok, string req, string act, string exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endfunction

    function automatic void take(ref item_t q[$], input logic [79:0] act, input string kind);
        item_t it;
        if (q.size() == 0) begin
            check(0, kind, $sformatf("unexpected @%0d %h", cyc, act), "none");
            return;
        end
        it = q.pop_front();
        check(it.cyc == cyc && it.d == act, it.req,
              $sformatf("%s @%0d %h", kind, cyc, act), $sformatf("@%0d %h", it.cyc, it.d));
    endfunction

    always @(negedge clk) if (!rst) begin
        if (pack_done)  take(q_pack, pack_code, "pack");
        if (load_valid) take(q_load, {70'd0, load_value}, "load");
        if (fix_we)     take(q_fix, {63'd0, fix_addr, fix_xor}, "fix");
        if (corr_done)  take(q_done, {76'd0, corr_fail, corr_count}, "done");
    end

    function automatic logic [79:0] exp_pack(logic [127:0] w);
        logic [79:0] r;
        logic [31:0] p0, p1;
        for (int i = 0; i < 2; i++) begin
            p0 = w[64*i +: 32] & 32'h03FF03FF;
            p1 = w[64*i+32 +: 32] & 32'h03FF03FF;
            r[40*i +: 8]      = p0[7:0];
            r[40*i+8 +: 8]    = 8'((p0 >> 8) & 32'h3) | 8'((p0 >> 14) & 32'hFC);
            r[40*i+16 +: 8]   = 8'((p0 >> 22) & 32'hF) | 8'((p1 << 4) & 32'hF0);
            r[40*i+24 +: 8]   = 8'((p1 >> 4) & 32'h3F) | 8'((p1 >> 10) & 32'hC0);
            r[40*i+32 +: 8]   = 8'((p1 >> 18) & 32'hFF);
        end
        return r;
    endfunction

    task automatic do_pack(logic [127:0] w);
        @(negedge clk);
        q_pack.push_back('{cyc + 1, exp_pack(w), "R1"});
        chk_words = w; pack_valid = 1;
        @(negedge clk); pack_valid = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_unpack(logic [79:0] c, bit poke);
        int c0;
        @(negedge clk);
        c0 = cyc;
        for (int i = 0; i < 8; i++) q_load.push_back('{c0 + 1 + i, {70'd0, c[10*(7-i) +: 10]}, "R2"});
        unpack_code = c; unpack_valid = 1;
        @(negedge clk); unpack_valid = 0;
        if (poke) begin
            @(negedge clk);
            unpack_code = ~c; unpack_valid = 1;  // R2: ignored while streaming
            @(negedge clk); unpack_valid = 0;
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic run_corr(logic [127:0] syn, bit busyf, int extra, logic [3:0] st,
                            logic [1:0] nb, logic [63:0] ad, logic [63:0] vl, string req);
        int c0, p, n, applied;
        logic [31:0] aw, vw;
        logic [15:0] ah, vh;
        logic [9:0]  a10;
        @(negedge clk);
        c0 = cyc;
        err_addr = ad; err_val = vl; syndrome = syn;
        eng_state = busyf ? 4'd4 : st; eng_errs = nb;
        corr_start = 1;
        if (((syn[31:0] | syn[63:32] | syn[95:64] | syn[127:96]) & 32'h03FF03FF) == 0) begin
            q_done.push_back('{c0 + 1, 80'd0, req});
        end else begin
            p = busyf ? c0 + 3 + extra : c0 + 2 + TMO;
            if (st == 0 || st == 1) q_done.push_back('{p, {76'd0, st[0], 3'd0}, req});
            else begin
                n = 1 + int'(nb); applied = 0;
                for (int k = 0; k < n; k++) begin
                    aw = ad[32*(k/2) +: 32]; vw = vl[32*(k/2) +: 32];
                    ah = (k % 2) ? aw[31:16] : aw[15:0];
                    vh = (k % 2) ? vw[31:16] : vw[15:0];
                    a10 = ah[9:0];
                    if (a10 >= 8 && a10 <= 519) begin
                        q_fix.push_back('{p + 1 + k, {63'd0, 9'(519 - int'(a10)), vh[7:0]}, req});
                        applied++;
                    end
                end
                q_done.push_back('{p + n, {76'd0, 1'b0, 3'(applied)}, req});
            end
        end
        @(negedge clk); corr_start = 0;
        if (busyf) begin
            @(negedge clk);
            if (extra > 0) begin
                eng_state = 4'hC;  // R10
                repeat (extra) @(negedge clk);
            end
            eng_state = st;
        end
        repeat (TMO + 12) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", "timeout", "finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!pack_done && !load_valid && !fix_we && !corr_done, "R9 reset",
              $sformatf("%b%b%b%b", pack_done, load_valid, fix_we, corr_done), "0000");
        // R1: packing with garbage outside the value fields
        do_pack({32'h0155_02AA, 32'h03FF_0000, 32'h0000_03FF, 32'h0123_0321});
        do_pack({4{32'hFC00_FC00}});
        do_pack({32'hFFFF_FFFF, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F});
        // R2: reverse-order feed, second request while busy ignored
        do_unpack(80'h1234_5678_9ABC_DEF0_1357, 1);
        do_unpack(80'hFFEE_0011_2233_4455_6677, 0);
        // R3: only masked-out syndrome bits set
        run_corr({4{32'hFC00_FC00}}, 1, 0, 4'd2, 2'd0, 64'd8, 64'd1, "R3");
        // R7 R8 R9: four errors, one landing in the spare area
        run_corr(128'd1, 1, 0, 4'd2, 2'd3, {16'd300, 16'd5, 16'd519, 16'd8},
                 {16'h00C3, 16'h0077, 16'h0055, 16'h00A5}, "R7 R8 R9");
        // R4: done shown from the start is ignored until timeout
        run_corr(128'h10, 0, 0, 4'd3, 2'd0, 64'd100, 64'h3C, "R4");
        // R10 R8: busy values hold polling; address above 519 skipped
        run_corr(128'd1 << 100, 1, 3, 4'd2, 2'd0, 64'h3FF, 64'h11, "R10 R8");
        // R6: uncorrectable
        run_corr(128'd1, 1, 0, 4'd1, 2'd2, 64'd20, 64'h1, "R6");
        // R5: state 0 while polling
        run_corr(128'd1, 1, 1, 4'd0, 2'd1, 64'd20, 64'h1, "R5");
        // R8: upper address bits ignored, value low byte only
        run_corr(128'd1, 1, 0, 4'd3, 2'd1, {32'd0, 16'hFC08, 16'hA400}, {32'd0, 16'hBB5A, 16'h7E81}, "R8 R7");
        check(q_pack.size() == 0 && q_load.size() == 0, "R1 R2 pending",
              $sformatf("%0d %0d", q_pack.size(), q_load.size()), "0 0");
        check(q_fix.size() == 0 && q_done.size() == 0, "R9 pending",
              $sformatf("%0d %0d", q_fix.size(), q_done.size()), "0 0");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule